// File: doc/BRIEF.md
# Non-Power-of-Two Dual-Clock FIFO

This block is a first-in first-out buffer that moves data words from a fast write clock domain to a slower read clock domain. Its storage holds exactly 688 words. Because 688 is not a power of two, the usual Gray-coded pointer scheme does not apply. Each side instead keeps a plain binary pointer that counts through the 688 slots and flips an extra lap bit each time it returns to slot zero.

A pointer never crosses the clock boundary by being sampled directly. The owning side takes a snapshot, holds it steady and toggles a request line. The far side synchronizes that toggle, captures the snapshot and returns an acknowledge toggle. The live pointer keeps moving while a transfer is in flight, so writes never wait on the handshake. Full is computed in the write domain and empty in the read domain, each against the last copy of the far pointer that arrived. That copy may be stale, so each flag can only be pessimistic.

The producer drives a word with a valid strobe and watches the full flag. The consumer raises ready when empty is low and receives the word on the following read clock. Each domain has its own asynchronous active-low reset, released synchronously inside the block.

Top module: `dcf_fifo`

## Requirements
- R1: The buffer accepts exactly 688 words with no reads in between. `wr_full` is low until the 688th word is accepted and high afterwards.
- R2: Words leave in the order they entered, with their values unchanged.
- R3: Each pointer counts slots 0 to 687 and then goes back to 0, toggling its lap bit. Data stays correct across any number of wraps.
- R4: A write offered while `wr_full` is high is discarded. It neither overwrites stored data nor moves the write pointer.
- R5: A read requested while `rd_empty` is high is discarded. `rd_data` keeps its value and the read pointer does not move.
- R6: `rd_data` is registered. It shows the popped word one read clock after the edge where `rd_ready` was high and `rd_empty` was low.
- R7: After reset of both domains, `rd_empty` is 1 and `wr_full` is 0. Words written before the reset are gone.
- R8: Writes are never stalled by a pointer transfer in flight. A burst with one word per write clock is fully accepted while real occupancy stays below 688.
- R9: `rd_empty` falls only after a written word's pointer has crossed the boundary. This takes at least one and at most 8 read clocks after the write in this bench's clock ratio.
- R10: After the reader drains a full buffer and the read pointer has crossed back, `wr_full` returns to 0.
- R11: A pointer snapshot offered to the far domain stays unchanged from the request toggle until the matching acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock (the faster one) |
| wrst_n | input | 1 | Asynchronous active-low reset of the write domain |
| wr_data | input | DATA_W | Word to store |
| wr_valid | input | 1 | Offers `wr_data` on this write clock edge |
| wr_full | output | 1 | No free slot from the write side's view |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Asynchronous active-low reset of the read domain |
| rd_ready | input | 1 | Requests a pop on this read clock edge |
| rd_data | output | DATA_W | Registered word from the last accepted pop |
| rd_empty | output | 1 | No stored word from the read side's view |

## Verification
The hardest condition to reach is a completely full buffer while the write side holds an exact copy of the read pointer. To get there, the bench first lets several hundred words pass through, so both pointers are well away from zero. It then waits for the handshakes to settle and writes precisely the remaining free count, which wraps the write pointer past slot 687 before full asserts. Rejected writes are offered at that point, and the bench proves them lost by draining all 688 words. A long run with writer and reader working at once then wraps both pointers again while snapshots are constantly in flight.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // default storage size and word width
  localparam int unsigned DEF_DEPTH  = 688;
  localparam int unsigned DEF_DATA_W = 16;
  // flops in each synchronizer chain
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/dcf_rstsync.sv
module dcf_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dcf_ptr.sv
module dcf_ptr #(
  parameter int unsigned DEPTH  = 688,
  parameter int unsigned ADDR_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  output logic [ADDR_W:0] ptr     // {lap, slot}
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              lap_q, lap_d;

  always_comb begin
    addr_d = addr_q;
    lap_d  = lap_q;
    if (addr_q == ADDR_W'(DEPTH - 1)) begin
      addr_d = '0;
      lap_d  = ~lap_q;
    end else begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lap_q  <= 1'b0;
    end else if (inc) begin
      addr_q <= addr_d;
      lap_q  <= lap_d;
    end
  end

  assign ptr = {lap_q, addr_q};

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= ADDR_W'(DEPTH - 1));

  // R3
  lap_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && addr_q == ADDR_W'(DEPTH - 1)) |=> (addr_q == '0 && lap_q != $past(lap_q)));
endmodule

// File: rtl/dcf_xfer.sv
module dcf_xfer #(
  parameter int unsigned PTR_W  = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [PTR_W-1:0] src_ptr,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [PTR_W-1:0] dst_ptr
);
  // source side
  logic [PTR_W-1:0]  snap_q, snap_d;
  logic              req_q, req_d;
  logic [STAGES-1:0] ack_sh_q;
  logic              ack_seen, idle, launch;
  // destination side
  logic [STAGES-1:0] req_sh_q;
  logic              tog_q, take;
  logic [PTR_W-1:0]  rx_q;

  assign ack_seen = ack_sh_q[STAGES-1];
  assign idle     = (req_q == ack_seen);
  assign launch   = idle && (src_ptr != snap_q);

  always_comb begin
    snap_d = snap_q;
    req_d  = req_q;
    if (launch) begin
      snap_d = src_ptr;
      req_d  = ~req_q;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      snap_q   <= '0;
      req_q    <= 1'b0;
      ack_sh_q <= '0;
    end else begin
      ack_sh_q <= {ack_sh_q[STAGES-2:0], tog_q};
      if (launch) begin
        snap_q <= snap_d;
        req_q  <= req_d;
      end
    end
  end

  assign take = (req_sh_q[STAGES-1] != tog_q);

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_sh_q <= '0;
      tog_q    <= 1'b0;
      rx_q     <= '0;
    end else begin
      req_sh_q <= {req_sh_q[STAGES-2:0], req_q};
      if (take) begin
        tog_q <= req_sh_q[STAGES-1];
        rx_q  <= snap_q;
      end
    end
  end

  assign dst_ptr = rx_q;

  // R11
  snap_hold_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !idle |=> $stable(snap_q));
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int unsigned DEPTH  = 688,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata_q <= '0;
    else if (re)  rdata_q <= mem_q[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int unsigned DEPTH       = dcf_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W      = dcf_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = dcf_pkg::DEF_SYNC
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PTR_W  = ADDR_W + 1;
  localparam int unsigned USE_W  = ADDR_W + 2;

  logic             w_rst_n, r_rst_n;
  logic [PTR_W-1:0] wptr, rptr, rfar, wfar;
  logic             wr_push, rd_pop;
  logic [USE_W-1:0] wr_used;

  dcf_rstsync #(.STAGES(SYNC_STAGES)) i_wrst (
    .clk(wclk), .arst_n(wrst_n), .rst_n(w_rst_n));
  dcf_rstsync #(.STAGES(SYNC_STAGES)) i_rrst (
    .clk(rclk), .arst_n(rrst_n), .rst_n(r_rst_n));

  assign wr_full  = (wptr[ADDR_W-1:0] == rfar[ADDR_W-1:0]) &&
                    (wptr[ADDR_W] != rfar[ADDR_W]);
  assign rd_empty = (rptr == wfar);
  assign wr_push  = wr_valid && !wr_full;
  assign rd_pop   = rd_ready && !rd_empty;

  dcf_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_wptr (
    .clk(wclk), .rst_n(w_rst_n), .inc(wr_push), .ptr(wptr));
  dcf_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_rptr (
    .clk(rclk), .rst_n(r_rst_n), .inc(rd_pop), .ptr(rptr));

  dcf_xfer #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) i_w2r (
    .src_clk(wclk), .src_rst_n(w_rst_n), .src_ptr(wptr),
    .dst_clk(rclk), .dst_rst_n(r_rst_n), .dst_ptr(wfar));
  dcf_xfer #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) i_r2w (
    .src_clk(rclk), .src_rst_n(r_rst_n), .src_ptr(rptr),
    .dst_clk(wclk), .dst_rst_n(w_rst_n), .dst_ptr(rfar));

  dcf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .wclk(wclk), .we(wr_push), .waddr(wptr[ADDR_W-1:0]), .wdata(wr_data),
    .rclk(rclk), .rrst_n(r_rst_n), .re(rd_pop), .raddr(rptr[ADDR_W-1:0]),
    .rdata(rd_data));

  // occupancy as the write side sees it, used only for checking
  always_comb begin
    if (wptr[ADDR_W] == rfar[ADDR_W])
      wr_used = USE_W'(wptr[ADDR_W-1:0]) - USE_W'(rfar[ADDR_W-1:0]);
    else
      wr_used = USE_W'(DEPTH) + USE_W'(wptr[ADDR_W-1:0]) - USE_W'(rfar[ADDR_W-1:0]);
  end

  // R1
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wr_used <= USE_W'(DEPTH));

  // R4
  full_block_chk: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wr_full |=> $stable(wptr));

  // R5
  empty_block_chk: assert property (@(posedge rclk) disable iff (!r_rst_n)
    rd_empty |=> ($stable(rptr) && $stable(rd_data)));
endmodule

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 17;
  localparam int DEPTH       = 688;
  localparam int DW          = 16;

  // phase table: writes, then reads, then settled flags
  localparam int NPH = 5;
  localparam int PH_WR    [NPH] = '{5, 0, 300, 588, 0};
  localparam int PH_RD    [NPH] = '{0, 5, 200, 0, 688};
  localparam bit PH_EMPTY [NPH] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam bit PH_FULL  [NPH] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n, rrst_n;
  logic [DW-1:0] wr_data;
  logic wr_valid, wr_full, rd_ready, rd_empty;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  int stalls = 0;
  bit done = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] next_val = 16'h0100;

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dcf_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) i_dcf_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_full(wr_full), .rclk(rclk), .rrst_n(rrst_n), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_empty(rd_empty));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one word per write clock while not full
  task automatic push_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      while (wr_full) begin
        stalls++;
        wr_valid = 1'b0;
        @(negedge wclk);
      end
      wr_valid = 1'b1;
      wr_data  = next_val;
      model.push_back(next_val);
      next_val = next_val + 16'd1;
    end
    @(negedge wclk);
    wr_valid = 1'b0;
  endtask

  // back-to-back pops; data checked one read clock after each accepted pop
  task automatic pop_n(input int n);
    int  got = 0;
    bit  pend = 0;
    logic [DW-1:0] exp;
    while (got < n || pend) begin
      @(negedge rclk);
      if (pend) begin
        if (model.size() == 0) check(1'b0, "R2", "model underrun", 0, 1);
        else begin
          exp = model.pop_front();
          check(rd_data == exp, "R2/R6", "popped word", int'(rd_data), int'(exp));
        end
        pend = 0;
      end
      if (got < n && !rd_empty) begin
        rd_ready = 1'b1;
        pend = 1;
        got++;
      end else begin
        rd_ready = 1'b0;
      end
    end
    rd_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic do_reset();
    wrst_n = 1'b0; rrst_n = 1'b0;
    wr_valid = 1'b0; rd_ready = 1'b0; wr_data = '0;
    repeat (5) @(negedge rclk);
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (6) @(negedge rclk);
    model.delete();
  endtask

  initial begin
    logic [DW-1:0] held;
    int lat;
    do_reset();
    // R7: reset state
    @(negedge wclk);
    check(wr_full == 1'b0, "R7", "full after reset", int'(wr_full), 0);
    @(negedge rclk);
    check(rd_empty == 1'b1, "R7", "empty after reset", int'(rd_empty), 1);

    // table walk (R1, R2, R3, R8, R10)
    for (int p = 0; p < NPH; p++) begin
      stalls = 0;
      if (PH_WR[p] > 0) push_burst(PH_WR[p]);
      check(stalls == 0, "R8", "write stalls in burst", stalls, 0);
      if (PH_RD[p] > 0) pop_n(PH_RD[p]);
      settle();
      @(negedge rclk);
      check(rd_empty == PH_EMPTY[p], "R1", "settled empty", int'(rd_empty), int'(PH_EMPTY[p]));
      @(negedge wclk);
      check(wr_full == PH_FULL[p], p == 4 ? "R10" : "R1", "settled full",
            int'(wr_full), int'(PH_FULL[p]));
      if (p == 3) begin
        // R4: writes offered while full are dropped
        for (int k = 0; k < 6; k++) begin
          @(negedge wclk);
          wr_valid = 1'b1;
          wr_data  = 16'hDEAD;
          check(wr_full == 1'b1, "R4", "full held during rejected write", int'(wr_full), 1);
        end
        @(negedge wclk);
        wr_valid = 1'b0;
        check(wr_full == 1'b1, "R4", "full after rejected writes", int'(wr_full), 1);
      end
    end
    check(model.size() == 0, "R4", "leftover model words", model.size(), 0);

    // R5: reads while empty are ignored
    @(negedge rclk);
    held = rd_data;
    rd_ready = 1'b1;
    repeat (10) begin
      @(negedge rclk);
      check(rd_empty == 1'b1, "R5", "empty during ignored reads", int'(rd_empty), 1);
    end
    check(rd_data == held, "R5", "rd_data held", int'(rd_data), int'(held));
    rd_ready = 1'b0;

    // R9: empty falls only after the pointer crosses
    push_burst(1);
    lat = 0;
    @(negedge rclk);
    while (rd_empty && lat < 40) begin
      lat++;
      @(negedge rclk);
    end
    check(lat >= 1 && lat <= 8, "R9", "read clocks until not empty", lat, 4);
    pop_n(1);
    check(model.size() == 0, "R5", "single word after ignored reads", model.size(), 0);

    // R3/R8: concurrent traffic wraps both pointers again
    stalls = 0;
    fork
      push_burst(1000);
      pop_n(1000);
    join
    check(stalls == 0, "R8", "stalls during concurrent traffic", stalls, 0);
    settle();
    @(negedge rclk);
    check(rd_empty == 1'b1, "R3", "empty after concurrent drain", int'(rd_empty), 1);

    // R7: reset discards stored words
    push_burst(3);
    settle();
    do_reset();
    @(negedge rclk);
    check(rd_empty == 1'b1, "R7", "empty after mid-run reset", int'(rd_empty), 1);
    @(negedge wclk);
    check(wr_full == 1'b0, "R7", "full after mid-run reset", int'(wr_full), 0);
    push_burst(1);
    pop_n(1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule